// File: doc/BRIEF.md
# Transmit descriptor DMA controller

This block walks a chain of transmit descriptors in host memory and moves each packet fragment into the transmit data FIFO. Each descriptor is three 32-bit words at consecutive addresses: a link pointer at offset 0, a command/status word at offset 4 and a buffer pointer at offset 8. All memory traffic goes through an abstract burst port. The block presents a start pulse with an address, a byte length, a direction and a FIFO-destination flag. It then waits for a done strobe. Read data comes back one word per cycle, marked by a valid flag.

The controller keeps a current-descriptor pointer. Software loads this pointer while the block is idle. When a descriptor has been fully handled, it is remembered as done. If the chain ended with a NULL link, the next activation fetches only that descriptor's link word, so software can append descriptors to a running chain. Completion status is written back into the command/status word, which hands the descriptor back to software. Two single-cycle interrupt pulses report completions: one for a finished packet, one for reaching a descriptor that the block does not own.

Top module: `txdesc_dma`

## Requirements
- R1: After reset the descriptor pointer is 0, no burst is started and both interrupt pulses are low.
- R2: In idle, with transmit enabled, reset inactive and the current descriptor not done, the block starts a 12-byte host read at the descriptor pointer. The words return in the order link, command/status, buffer pointer.
- R3: When a descriptor read completes with the owner bit (bit 31 of command/status) clear, the block pulses `irq_txidle` once and returns to idle. It reads no fragment and leaves the pointer unchanged.
- R4: With the owner bit set, the block waits until `fifo_free` is at least the byte count (bits 11:0). It then starts a FIFO-destination read at the buffer pointer with that byte count as length. Equality is enough.
- R5: After the fragment burst completes, the block writes 4 bytes to pointer+4. The written word is the command/status word with bit 31 cleared, abort bit 26 cleared, bit 27 set exactly when the more-fragments bit (bit 30) is clear, and all other bits unchanged.
- R6: `irq_txok` pulses once when the status write of a descriptor with bit 30 clear completes. No pulse is raised for a descriptor with bit 30 set.
- R7: After a status write, a non-zero link is loaded into the pointer and the next descriptor is read in full.
- R8: A zero link leaves the pointer unchanged and marks the descriptor done. The next activation starts a 4-byte read of the link word at the pointer. A non-zero result then advances to the linked descriptor.
- R9: Deasserting enable or asserting `tx_reset` lets the running burst finish and then returns to idle. A fragment cut off this way gets no status write, and the descriptor is read again in full on restart.
- R10: A pointer load takes effect only in idle and clears the done mark. A load attempted in any other state is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous-style block reset, sampled synchronously |
| tx_enable | input | 1 | Transmit enable |
| tx_reset | input | 1 | Transmit reset; halts after the current burst |
| ptr_wr | input | 1 | Load strobe for the descriptor pointer |
| ptr_wdata | input | AW | Pointer value to load |
| desc_ptr | output | AW | Current descriptor pointer |
| fifo_free | input | FW | Free bytes in the transmit FIFO |
| xfer_start | output | 1 | One-cycle burst start |
| xfer_addr | output | AW | Burst host address |
| xfer_len | output | LW | Burst length in bytes |
| xfer_write | output | 1 | 1 = write to host, 0 = read from host |
| xfer_to_fifo | output | 1 | Read data goes to the transmit FIFO |
| xfer_wdata | output | 32 | Word written by a status burst |
| rsp_valid | input | 1 | Read word valid |
| rsp_data | input | 32 | Read word |
| xfer_done | input | 1 | Burst completion strobe |
| irq_txidle | output | 1 | Pulse: descriptor not owned by the block |
| irq_txok | output | 1 | Pulse: last descriptor of a packet written back |

## Verification
Each burst start appears one cycle after the clock edge that accepted its cause. Examples of causes are the enable in idle, the done strobe of the previous burst, or FIFO space becoming sufficient. The interrupt pulses appear one cycle after the edge that sampled the done strobe. The next descriptor fetch after a status write starts two edges after its done, because the block passes through the advance state and idle. The bench samples all outputs on falling edges, logs every burst start as it is seen, and waits on log length rather than fixed delays. This lets whole descriptor chains, with every pattern of more-fragment bits up to four descriptors, be compared event by event against values computed from the descriptor contents.

// File: rtl/txdesc_pkg.sv
package txdesc_pkg;

    typedef enum logic [2:0] {
        TD_IDLE,
        TD_FETCH,
        TD_RELINK,
        TD_ADVANCE,
        TD_SPACE,
        TD_FRAG,
        TD_WBACK
    } td_state_e;

    // command/status bit positions
    localparam int CS_OWN   = 31;
    localparam int CS_MORE  = 30;
    localparam int CS_OK    = 27;
    localparam int CS_ABORT = 26;
    localparam int SIZE_W   = 12;

    // descriptor layout in bytes
    localparam int DESC_BYTES = 12;
    localparam int WORD_BYTES = 4;
    localparam int CS_OFFSET  = 4;

endpackage

// File: rtl/txd_space_check.sv
module txd_space_check #(
    parameter int LW = 12,
    parameter int FW = 13
) (
    input  logic [LW-1:0] need,
    input  logic [FW-1:0] free,
    output logic          fits
);
    localparam int CW = (LW > FW) ? LW : FW;

    logic [CW-1:0] need_x;
    logic [CW-1:0] free_x;

    assign need_x = CW'(need);
    assign free_x = CW'(free);
    assign fits   = (free_x >= need_x);

endmodule

// File: rtl/txd_status_fmt.sv
module txd_status_fmt
    import txdesc_pkg::*;
(
    input  logic [31:0] cmdsts,
    output logic [31:0] status,
    output logic        last
);
    always_comb begin
        last             = !cmdsts[CS_MORE];
        status           = cmdsts;
        status[CS_OWN]   = 1'b0;
        status[CS_ABORT] = 1'b0;
        status[CS_OK]    = last;
    end

endmodule

// File: rtl/txdesc_dma.sv
module txdesc_dma
    import txdesc_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 12,
    parameter int FW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_enable,
    input  logic          tx_reset,
    input  logic          ptr_wr,
    input  logic [AW-1:0] ptr_wdata,
    output logic [AW-1:0] desc_ptr,
    input  logic [FW-1:0] fifo_free,
    output logic          xfer_start,
    output logic [AW-1:0] xfer_addr,
    output logic [LW-1:0] xfer_len,
    output logic          xfer_write,
    output logic          xfer_to_fifo,
    output logic [31:0]   xfer_wdata,
    input  logic          rsp_valid,
    input  logic [31:0]   rsp_data,
    input  logic          xfer_done,
    output logic          irq_txidle,
    output logic          irq_txok
);
    localparam logic [AW-1:0] CS_OFS   = AW'(CS_OFFSET);
    localparam logic [LW-1:0] LEN_DESC = LW'(DESC_BYTES);
    localparam logic [LW-1:0] LEN_WORD = LW'(WORD_BYTES);

    typedef struct packed {
        td_state_e     state;
        logic [AW-1:0] ptr;
        logic [AW-1:0] link;
        logic [AW-1:0] bufp;
        logic [31:0]   cmd;
        logic          cur_done;
        logic [1:0]    widx;
        logic          start;
        logic [AW-1:0] addr;
        logic [LW-1:0] len;
        logic          wr;
        logic          tofifo;
        logic [31:0]   wdata;
        logic          irq_idle;
        logic          irq_ok;
    } regs_t;

    regs_t q;
    regs_t d;

    logic          halt;
    logic          room_ok;
    logic [31:0]   wb_status;
    logic          wb_last;
    logic [LW-1:0] frag_len;

    assign halt     = !tx_enable || tx_reset;
    assign frag_len = LW'(q.cmd[SIZE_W-1:0]);

    txd_space_check #(.LW(LW), .FW(FW)) u_space (
        .need (frag_len),
        .free (fifo_free),
        .fits (room_ok)
    );

    txd_status_fmt u_fmt (
        .cmdsts (q.cmd),
        .status (wb_status),
        .last   (wb_last)
    );

    always_comb begin
        d          = q;
        d.start    = 1'b0;
        d.irq_idle = 1'b0;
        d.irq_ok   = 1'b0;
        unique case (q.state)
            TD_IDLE: begin
                if (ptr_wr) begin
                    d.ptr      = ptr_wdata;
                    d.cur_done = 1'b0;
                end else if (!halt) begin
                    d.start  = 1'b1;
                    d.addr   = q.ptr;
                    d.wr     = 1'b0;
                    d.tofifo = 1'b0;
                    d.widx   = '0;
                    if (q.cur_done) begin
                        d.len   = LEN_WORD;
                        d.state = TD_RELINK;
                    end else begin
                        d.len   = LEN_DESC;
                        d.state = TD_FETCH;
                    end
                end
            end
            TD_FETCH: begin
                if (rsp_valid) begin
                    case (q.widx)
                        2'd0:    d.link = AW'(rsp_data);
                        2'd1:    d.cmd  = rsp_data;
                        default: d.bufp = AW'(rsp_data);
                    endcase
                    d.widx = q.widx + 2'd1;
                end
                if (xfer_done) begin
                    if (halt) begin
                        d.state = TD_IDLE;
                    end else if (d.cmd[CS_OWN]) begin
                        d.state = TD_SPACE;
                    end else begin
                        d.state    = TD_IDLE;
                        d.irq_idle = 1'b1;
                    end
                end
            end
            TD_RELINK: begin
                if (rsp_valid) begin
                    d.link = AW'(rsp_data);
                end
                if (xfer_done) begin
                    d.state = halt ? TD_IDLE : TD_ADVANCE;
                end
            end
            TD_ADVANCE: begin
                if (q.link != '0) begin
                    d.ptr      = q.link;
                    d.cur_done = 1'b0;
                end else begin
                    d.cur_done = 1'b1;
                end
                d.state = TD_IDLE;
            end
            TD_SPACE: begin
                if (halt) begin
                    d.state = TD_IDLE;
                end else if (room_ok) begin
                    d.start  = 1'b1;
                    d.addr   = q.bufp;
                    d.len    = frag_len;
                    d.wr     = 1'b0;
                    d.tofifo = 1'b1;
                    d.state  = TD_FRAG;
                end
            end
            TD_FRAG: begin
                if (xfer_done) begin
                    if (halt) begin
                        d.state = TD_IDLE;
                    end else begin
                        d.start  = 1'b1;
                        d.addr   = q.ptr + CS_OFS;
                        d.len    = LEN_WORD;
                        d.wr     = 1'b1;
                        d.tofifo = 1'b0;
                        d.wdata  = wb_status;
                        d.state  = TD_WBACK;
                    end
                end
            end
            TD_WBACK: begin
                if (xfer_done) begin
                    d.cur_done = 1'b1;
                    d.irq_ok   = wb_last;
                    d.state    = halt ? TD_IDLE : TD_ADVANCE;
                end
            end
            default: d.state = TD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= TD_IDLE;
        end else begin
            q <= d;
        end
    end

    assign desc_ptr     = q.ptr;
    assign xfer_start   = q.start;
    assign xfer_addr    = q.addr;
    assign xfer_len     = q.len;
    assign xfer_write   = q.wr;
    assign xfer_to_fifo = q.tofifo;
    assign xfer_wdata   = q.wdata;
    assign irq_txidle   = q.irq_idle;
    assign irq_txok     = q.irq_ok;

    // a burst request lasts exactly one cycle
    assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start);

    // host reads not aimed at the FIFO are descriptor or link fetches
    assert_fetch_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start && !xfer_write && !xfer_to_fifo) |-> (xfer_len == LEN_DESC || xfer_len == LEN_WORD));

    // a fragment is only requested when the FIFO had room for it
    assert_frag_fits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start && xfer_to_fifo) |-> (32'($past(fifo_free)) >= 32'(xfer_len)));

    // write-back releases ownership and targets the status word
    assert_wb_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start && xfer_write) |-> (!xfer_wdata[CS_OWN] && xfer_addr == desc_ptr + CS_OFS));

    // the two completion pulses never coincide
    assert_irq_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_txok && irq_txidle));

    // pointer holds while a descriptor is in flight
    assert_ptr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state inside {TD_FETCH, TD_RELINK, TD_SPACE, TD_FRAG, TD_WBACK}) |=> $stable(desc_ptr));

endmodule

// File: tb/txdesc_dma_test.sv
module txdesc_dma_test;
    localparam int AW = 32;
    localparam int LW = 12;
    localparam int FW = 13;
    localparam logic [31:0] OWN  = 32'h8000_0000;
    localparam logic [31:0] MORE = 32'h4000_0000;
    localparam logic [31:0] OKB  = 32'h0800_0000;
    localparam logic [31:0] ABT  = 32'h0400_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_main = 1'b0;
    int   arm_cnt = 0, used_cnt = 0, drop_cnt = 0, ack_cnt = 0, arm_sel = 0;
    logic rst_req = 1'b0;
    logic tx_enable;
    logic tx_reset;
    logic ptr_wr = 1'b0;
    logic [AW-1:0] ptr_wdata = '0;
    logic [FW-1:0] fifo_free = 13'd4095;
    logic rsp_valid = 1'b0;
    logic [31:0] rsp_data = '0;
    logic xfer_done = 1'b0;
    logic [AW-1:0] desc_ptr, xfer_addr;
    logic [LW-1:0] xfer_len;
    logic xfer_start, xfer_write, xfer_to_fifo, irq_txidle, irq_txok;
    logic [31:0] xfer_wdata;

    assign tx_enable = en_main && (drop_cnt == ack_cnt);
    assign tx_reset  = rst_req;

    logic [31:0] mem [0:255];
    int          ev_kind [0:1023];
    logic [31:0] ev_addr [0:1023];
    int          ev_len  [0:1023];
    logic [31:0] ev_data [0:1023];
    int n_ev = 0;
    int n_cmp = 0, n_bad = 0, cnt_ok = 0, cnt_idle = 0;
    bit finished = 1'b0;

    txdesc_dma #(.AW(AW), .LW(LW), .FW(FW)) uut (
        .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .tx_reset(tx_reset),
        .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata), .desc_ptr(desc_ptr), .fifo_free(fifo_free),
        .xfer_start(xfer_start), .xfer_addr(xfer_addr), .xfer_len(xfer_len),
        .xfer_write(xfer_write), .xfer_to_fifo(xfer_to_fifo), .xfer_wdata(xfer_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .xfer_done(xfer_done),
        .irq_txidle(irq_txidle), .irq_txok(irq_txok)
    );

    initial forever #5 clk = ~clk;

    function automatic logic [31:0] status_of(input logic [31:0] c);
        return (c & ~OWN & ~ABT) | (((c & MORE) != 0) ? 32'h0 : OKB);
    endfunction

    task automatic chk(input bit good, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (!good) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_ev(input int idx, input int k, input logic [31:0] a, input int l,
                          input logic [31:0] dt, input string req);
        int j;
        bit good;
        j = idx & 1023;
        good = (idx < n_ev) && ev_kind[j] == k && ev_addr[j] == a && ev_len[j] == l && ev_data[j] == dt;
        chk(good, req, $sformatf("burst %0d {kind,len,addr,data}", idx),
            {ev_kind[j][7:0], ev_len[j][23:0], ev_addr[j], ev_data[j], 32'h0},
            {k[7:0], l[23:0], a, dt, 32'h0});
    endtask

    // host memory model: answers every burst request
    task automatic serve();
        int k;
        int l;
        logic [31:0] a;
        a = xfer_addr;
        l = int'(xfer_len);
        if (xfer_write) k = 3;
        else if (xfer_to_fifo) k = 2;
        else if (l == 12) k = 0;
        else k = 1;
        ev_kind[n_ev & 1023] = k;
        ev_addr[n_ev & 1023] = a;
        ev_len[n_ev & 1023]  = l;
        ev_data[n_ev & 1023] = (k == 3) ? xfer_wdata : 32'h0;
        n_ev++;
        if (k <= 1) begin
            if (k == 0 && arm_cnt != used_cnt && arm_sel == 2) begin
                used_cnt = arm_cnt;
                rst_req = 1'b1;
            end
            for (int w = 0; w < l / 4; w++) begin
                @(negedge clk);
                rsp_valid = 1'b1;
                rsp_data  = mem[((a >> 2) + 32'(w)) & 32'hFF];
            end
            @(negedge clk);
            rsp_valid = 1'b0;
            xfer_done = 1'b1;
            @(negedge clk);
            xfer_done = 1'b0;
            rst_req   = 1'b0;
        end else if (k == 2) begin
            repeat (2) @(negedge clk);
            if (arm_cnt != used_cnt && arm_sel == 1) begin
                used_cnt = arm_cnt;
                drop_cnt++;
            end
            xfer_done = 1'b1;
            @(negedge clk);
            xfer_done = 1'b0;
        end else begin
            @(negedge clk);
            xfer_done = 1'b1;
            @(negedge clk);
            xfer_done = 1'b0;
        end
    endtask

    initial begin
        forever begin
            if (xfer_start === 1'b1) serve();
            else @(negedge clk);
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (irq_txok === 1'b1) cnt_ok++;
            if (irq_txidle === 1'b1) cnt_idle++;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic put_desc(input logic [31:0] a, input logic [31:0] lk,
                            input logic [31:0] c, input logic [31:0] b);
        mem[(a >> 2) & 32'hFF]       = lk;
        mem[((a >> 2) + 1) & 32'hFF] = c;
        mem[((a >> 2) + 2) & 32'hFF] = b;
    endtask

    task automatic load_ptr(input logic [31:0] v);
        @(negedge clk);
        ptr_wr = 1'b1;
        ptr_wdata = v;
        @(negedge clk);
        ptr_wr = 1'b0;
        chk(desc_ptr == v, "R10", "pointer load in idle", 128'(desc_ptr), 128'(v));
    endtask

    task automatic wait_ev(input int base, input int k);
        while (n_ev - base < k) @(negedge clk);
    endtask

    task automatic settle();
        en_main = 1'b0;
        repeat (20) @(negedge clk);
    endtask

    task automatic run_chain(input int n, input int mp);
        logic [31:0] da [4];
        logic [31:0] cm [4];
        logic [31:0] bf [4];
        int sz [4];
        int base, ok0, nok;
        bit more;
        nok = 0;
        for (int i = 0; i < n; i++) begin
            da[i] = 32'h100 + 32'(16 * i);
            sz[i] = (n * 37 + i * 101 + mp * 53 + 5) % 300;
            more  = (i < n - 1) && (((mp >> i) & 1) == 1);
            if (!more) nok++;
            cm[i] = OWN | (more ? MORE : 32'h0) | (((i % 2) == 1) ? ABT : 32'h0)
                    | ((i == 2) ? 32'h0010_0000 : 32'h0) | 32'(sz[i]);
            bf[i] = 32'h4000_0000 + 32'(256 * i + n);
            put_desc(da[i], (i == n - 1) ? 32'h0 : da[i] + 32'd16, cm[i], bf[i]);
        end
        load_ptr(32'h100);
        base = n_ev;
        ok0 = cnt_ok;
        en_main = 1'b1;
        wait_ev(base, 3 * n + 1);
        settle();
        for (int i = 0; i < n; i++) begin
            chk_ev(base + 3 * i, 0, da[i], 12, 32'h0, "R2");
            chk_ev(base + 3 * i + 1, 2, bf[i], sz[i], 32'h0, "R4");
            chk_ev(base + 3 * i + 2, 3, da[i] + 32'd4, 4, status_of(cm[i]), "R5");
        end
        chk_ev(base + 3 * n, 1, da[n - 1], 4, 32'h0, "R8");
        chk(desc_ptr == da[n - 1], "R7", "pointer at chain end", 128'(desc_ptr), 128'(da[n - 1]));
        chk(cnt_ok - ok0 == nok, "R6", "packet-done pulses", 128'(cnt_ok - ok0), 128'(nok));
    endtask

    initial begin
        int base, i0, o0, nfrag;
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        repeat (5) @(negedge clk);
        chk(desc_ptr == 32'h0 && xfer_start == 1'b0 && irq_txok == 1'b0 && irq_txidle == 1'b0,
            "R1", "reset state", {desc_ptr, 3'(0), xfer_start, irq_txok, irq_txidle},
            128'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(desc_ptr == 32'h0 && n_ev == 0, "R1", "idle without enable", 128'(n_ev), 128'h0);

        // R2 R5 R6 R7 R8: every more-bit pattern for chains of 1..4
        for (int n = 1; n <= 4; n++)
            for (int mp = 0; mp < (1 << (n - 1)); mp++)
                run_chain(n, mp);

        // R8: append to a finished chain via a link refresh
        run_chain(2, 1);
        mem[32'h110 >> 2] = 32'h300;
        put_desc(32'h300, 32'h0, OWN | 32'd40, 32'h5000_0000);
        base = n_ev;
        en_main = 1'b1;
        wait_ev(base, 5);
        settle();
        chk_ev(base, 1, 32'h110, 4, 32'h0, "R8");
        chk_ev(base + 1, 0, 32'h300, 12, 32'h0, "R8");
        chk_ev(base + 2, 2, 32'h5000_0000, 40, 32'h0, "R4");
        chk_ev(base + 3, 3, 32'h304, 4, status_of(OWN | 32'd40), "R5");
        chk(desc_ptr == 32'h300, "R8", "pointer after refresh", 128'(desc_ptr), 128'h300);

        // R3: descriptor not owned
        put_desc(32'h200, 32'h210, 32'd20, 32'h6000_0000);
        load_ptr(32'h200);
        base = n_ev;
        i0 = cnt_idle;
        o0 = cnt_ok;
        en_main = 1'b1;
        while (cnt_idle == i0) @(negedge clk);
        settle();
        chk_ev(base, 0, 32'h200, 12, 32'h0, "R3");
        nfrag = 0;
        for (int e = base; e < n_ev; e++) if (ev_kind[e & 1023] != 0) nfrag++;
        chk(nfrag == 0, "R3", "bursts other than fetch", 128'(nfrag), 128'h0);
        chk(desc_ptr == 32'h200, "R3", "pointer unchanged", 128'(desc_ptr), 128'h200);
        chk(cnt_ok == o0, "R3", "no packet-done pulse", 128'(cnt_ok), 128'(o0));

        // R4 R10: FIFO one byte short, then exactly enough
        put_desc(32'h200, 32'h0, OWN | 32'd100, 32'h7000_0000);
        fifo_free = 13'd99;
        load_ptr(32'h200);
        base = n_ev;
        en_main = 1'b1;
        repeat (30) @(negedge clk);
        chk(n_ev - base == 1, "R4", "bursts while FIFO short", 128'(n_ev - base), 128'h1);
        @(negedge clk);
        ptr_wr = 1'b1;
        ptr_wdata = 32'h3F0;
        @(negedge clk);
        ptr_wr = 1'b0;
        chk(desc_ptr == 32'h200, "R10", "load ignored while busy", 128'(desc_ptr), 128'h200);
        fifo_free = 13'd100;
        wait_ev(base, 4);
        settle();
        fifo_free = 13'd4095;
        chk_ev(base + 1, 2, 32'h7000_0000, 100, 32'h0, "R4");
        chk_ev(base + 2, 3, 32'h204, 4, status_of(OWN | 32'd100), "R10");

        // R9: enable dropped during the fragment burst
        put_desc(32'h200, 32'h0, OWN | 32'd64, 32'h7100_0000);
        load_ptr(32'h200);
        arm_sel = 1;
        arm_cnt++;
        base = n_ev;
        en_main = 1'b1;
        wait_ev(base, 2);
        repeat (20) @(negedge clk);
        chk(n_ev - base == 2, "R9", "no write-back after cut fragment", 128'(n_ev - base), 128'h2);
        chk(desc_ptr == 32'h200, "R9", "pointer held", 128'(desc_ptr), 128'h200);
        en_main = 1'b0;
        ack_cnt = drop_cnt;
        repeat (2) @(negedge clk);
        en_main = 1'b1;
        wait_ev(base, 6);
        settle();
        chk_ev(base + 2, 0, 32'h200, 12, 32'h0, "R9");
        chk_ev(base + 4, 3, 32'h204, 4, status_of(OWN | 32'd64), "R9");

        // R9: transmit reset during the descriptor fetch
        put_desc(32'h200, 32'h0, OWN | 32'd8, 32'h7200_0000);
        load_ptr(32'h200);
        arm_sel = 2;
        arm_cnt++;
        base = n_ev;
        en_main = 1'b1;
        wait_ev(base, 5);
        settle();
        chk_ev(base, 0, 32'h200, 12, 32'h0, "R9");
        chk_ev(base + 1, 0, 32'h200, 12, 32'h0, "R9");
        chk_ev(base + 2, 2, 32'h7200_0000, 8, 32'h0, "R9");

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule